// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Compare Channels

This block keeps a 64-bit up-counter that steps by one on every clock cycle in which the tick-enable input is high. With a tick enable pulsed once per microsecond, the counter is a microsecond time base that never stops and never reloads. Software reads the count as two 32-bit words, low then high. Because the words come from separate reads, software rereads the high word to detect a carry between the two reads.

Four compare channels each hold a 32-bit target. A target is matched against the low word of the counter only. When the low word takes a channel's target value on a tick, that channel's bit in a shared status word is set. The bit is also driven out as a level interrupt. The bit stays set until software writes a one to it. Writing a zero to a status bit leaves it unchanged.

Access is through a single-cycle word-addressed register port. A write is accepted on any clock edge where the write strobe is high. Read data is a combinational function of the address. The port never stalls, so it has no valid/ready handshake and no back-pressure.

Top module: `freerun_cmp_timer`

## Requirements
- R1: After reset the counter is zero, all compare registers are zero, all status bits are zero and every interrupt output is low.
- R2: The counter increases by exactly one at each clock edge where tick_en is high, and holds its value when tick_en is low. Word 1 reads counter bits 31:0 and word 2 reads counter bits 63:32.
- R3: Word 0 is the status word, with bit n belonging to channel n and bits 31:4 reading zero. Word 7 reads zero, and writes to it have no effect.
- R4: Words 3, 4, 5 and 6 are the compare registers of channels 0 to 3. They are writable and read back all 32 bits exactly as written.
- R5: A channel's status bit is set at the clock edge where a tick makes the counter low word equal to that channel's compare value. A low word that already equals a newly written compare value, with no tick, sets nothing.
- R6: A set status bit stays set through further ticks and further matches until it is cleared.
- R7: A write to word 0 clears every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged.
- R8: When a match and a clearing write hit the same bit at the same edge, the bit ends up set.
- R9: Interrupt output n is high exactly while status bit n is set.
- R10: Writes to words 1 and 2 are ignored, and the counter keeps its value.
- R11: Writing a compare register does not clear that channel's pending status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable, one cycle per microsecond |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Level interrupt per compare channel |

## Verification
The assertions check these properties on every cycle:
- the counter steps by exactly one on a tick and holds without one;
- no status bit rises in a cycle without a tick;
- a set bit only falls when a write to the status word asks for it;
- the status word read through the bus always agrees with the interrupt pins;
- unmapped words read zero.

Some behaviour needs set-up sequences, so only the bench scenarios show it. One case is a compare value written equal to the current low word with no tick, which must set nothing. Another is a tick-driven match landing in the same cycle as a clearing write. A third is a compare rewrite that leaves a pending flag in place. The bench also checks which specific channel fires at which count, and that writes to the counter words are dropped.

// File: rtl/freerun_cmp_timer_pkg.sv
package freerun_cmp_timer_pkg;

  // Word offsets of the register port; the order is fixed by behaviour.
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_CNT_LO = 1;
  localparam int unsigned OFS_CNT_HI = 2;
  localparam int unsigned OFS_CMP0   = 3;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CMP    = 2'd2
  } wr_sel_e;

  // True when a word offset falls inside the compare block.
  function automatic logic is_cmp_ofs(input int unsigned ofs, input int unsigned nch);
    return (ofs >= OFS_CMP0) && (ofs < OFS_CMP0 + nch);
  endfunction

endpackage

// File: rtl/freerun_cmp_timer_counter.sv
module freerun_cmp_timer_counter #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [WORD_W-1:0] lo_next
);

  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] hi_q;
  logic [WORD_W:0]   lo_sum;
  logic              lo_carry;

  // One adder feeds both the count register and the compare channels.
  assign lo_sum   = {1'b0, lo_q} + {{WORD_W{1'b0}}, 1'b1};
  assign lo_next  = lo_sum[WORD_W-1:0];
  assign lo_carry = lo_sum[WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (tick_en) begin
      lo_q <= lo_next;
      if (lo_carry) begin
        hi_q <= hi_q + {{(WORD_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assign cnt_q = {hi_q, lo_q};

endmodule

// File: rtl/freerun_cmp_timer_channel.sv
module freerun_cmp_timer_channel #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [WORD_W-1:0] lo_next,
  input  logic              cmp_we,
  input  logic [WORD_W-1:0] cmp_wdata,
  input  logic              flag_clr,
  output logic [WORD_W-1:0] cmp_q,
  output logic              flag_q
);

  logic hit;

  // A hit only counts when a tick moves the low word onto the target.
  assign hit = tick_en && (lo_next == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_we) begin
      cmp_q <= cmp_wdata;
    end
  end

  // Set dominates clear so that an event coinciding with a clear is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/freerun_cmp_timer_regs.sv
module freerun_cmp_timer_regs
  import freerun_cmp_timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [WORD_W-1:0]            bus_wdata,
  input  logic [CNT_W-1:0]             cnt_q,
  input  logic [NUM_CH-1:0][WORD_W-1:0] cmp_q,
  input  logic [NUM_CH-1:0]            flags_q,
  output logic [NUM_CH-1:0]            cmp_we,
  output logic [NUM_CH-1:0]            flag_clr,
  output logic [WORD_W-1:0]            bus_rdata
);

  wr_sel_e     wr_sel;
  int unsigned ofs;

  assign ofs = int'(bus_addr);

  always_comb begin
    wr_sel = SEL_NONE;
    if (bus_wr) begin
      if (ofs == OFS_STATUS) begin
        wr_sel = SEL_STATUS;
      end else if (is_cmp_ofs(ofs, NUM_CH)) begin
        wr_sel = SEL_CMP;
      end
    end
  end

  // Write-one-to-clear mask for the shared status word.
  assign flag_clr = (wr_sel == SEL_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    cmp_we = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if ((wr_sel == SEL_CMP) && (ofs == OFS_CMP0 + i)) begin
        cmp_we[i] = 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ofs == OFS_STATUS) begin
      bus_rdata[NUM_CH-1:0] = flags_q;
    end else if (ofs == OFS_CNT_LO) begin
      bus_rdata = cnt_q[WORD_W-1:0];
    end else if (ofs == OFS_CNT_HI) begin
      bus_rdata = cnt_q[CNT_W-1:WORD_W];
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ofs == OFS_CMP0 + i) begin
          bus_rdata = cmp_q[i];
        end
      end
    end
  end

endmodule

// File: rtl/freerun_cmp_timer.sv
module freerun_cmp_timer #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int unsigned CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0]              cnt_q;
  logic [WORD_W-1:0]             lo_next;
  logic [NUM_CH-1:0][WORD_W-1:0] cmp_q;
  logic [NUM_CH-1:0]             flags_q;
  logic [NUM_CH-1:0]             cmp_we;
  logic [NUM_CH-1:0]             flag_clr;

  freerun_cmp_timer_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_q   (cnt_q),
    .lo_next (lo_next)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    freerun_cmp_timer_channel #(.WORD_W(WORD_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .lo_next   (lo_next),
      .cmp_we    (cmp_we[g]),
      .cmp_wdata (bus_wdata),
      .flag_clr  (flag_clr[g]),
      .cmp_q     (cmp_q[g]),
      .flag_q    (flags_q[g])
    );
  end

  freerun_cmp_timer_regs #(
    .NUM_CH (NUM_CH),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .flags_q   (flags_q),
    .cmp_we    (cmp_we),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  assign irq = flags_q;

endmodule

// File: rtl/freerun_cmp_timer_chk.sv
module freerun_cmp_timer_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [NUM_CH-1:0] flags_q
);

  logic [NUM_CH-1:0] clr_req;
  assign clr_req = (bus_wr && (int'(bus_addr) == 0)) ? bus_wdata[NUM_CH-1:0] : '0;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

  // R5
  flag_rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ((flags_q & ~$past(flags_q)) == '0));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~$past(clr_req) & ~flags_q) == '0));

  // R9
  irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == 0) |-> (bus_rdata[NUM_CH-1:0] == irq));

  // R3
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) >= 3 + NUM_CH) |-> (bus_rdata == '0));

endmodule

bind freerun_cmp_timer freerun_cmp_timer_chk #(
  .NUM_CH (NUM_CH),
  .WORD_W (WORD_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_q     (cnt_q),
  .flags_q   (flags_q)
);

// File: tb/tb_freerun_cmp_timer.sv
module tb_freerun_cmp_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  freerun_cmp_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  localparam int VEC_N = 8;
  localparam logic [2:0]  V_ADDR [VEC_N] = '{3'd3, 3'd4, 3'd5, 3'd6, 3'd1, 3'd2, 3'd7, 3'd0};
  localparam logic [31:0] V_DATA [VEC_N] = '{32'hA5A5_5A5A, 32'hFFFF_FFFF, 32'h0000_0001,
                                             32'h8000_0000, 32'hDEAD_BEEF, 32'h1234_5678,
                                             32'h5555_5555, 32'hFFFF_FFFF};
  localparam logic [31:0] V_EXP  [VEC_N] = '{32'hA5A5_5A5A, 32'hFFFF_FFFF, 32'h0000_0001,
                                             32'h8000_0000, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam string V_REQ [VEC_N] = '{"R4", "R4", "R4", "R4", "R10", "R10", "R3", "R7"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across all words and pins
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1", v, 32'h0);
    end
    check("R1 irq", {28'h0, irq}, 32'h0);

    // Vector table: write then read back, with no ticks.
    for (int i = 0; i < VEC_N; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], v);
      check(V_REQ[i], v, V_EXP[i]);
    end

    // Targets: ch0=5, ch1=10, ch2=1000, ch3=3.
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd10);
    wr(3'd5, 32'd1000);
    wr(3'd6, 32'd3);

    ticks(3);
    rd(3'd1, v); check("R2 lo", v, 32'd3);
    rd(3'd2, v); check("R2 hi", v, 32'd0);
    rd(3'd0, v); check("R5 ch3", v, 32'h8);
    check("R9 irq3", {28'h0, irq}, 32'h8);

    ticks(2);
    rd(3'd1, v); check("R2 lo", v, 32'd5);
    rd(3'd0, v); check("R6 ch0+ch3", v, 32'h9);

    // R7: write one clears, write zero keeps.
    wr(3'd0, 32'h1);
    rd(3'd0, v); check("R7 clear bit0", v, 32'h8);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R7 zero keeps", v, 32'h8);

    // R11: rewrite ch3 target with flag pending.
    wr(3'd6, 32'd100);
    rd(3'd0, v); check("R11", v, 32'h8);
    wr(3'd0, 32'h8);
    rd(3'd0, v); check("R7 clear bit3", v, 32'h0);
    check("R9 irq clear", {28'h0, irq}, 32'h0);

    // R5: target equal to present low word without a tick.
    wr(3'd5, 32'd5);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R5 no tick", v, 32'h0);

    ticks(5);
    rd(3'd1, v); check("R2 lo", v, 32'd10);
    rd(3'd0, v); check("R5 ch1 only", v, 32'h2);
    check("R9 irq1", {28'h0, irq}, 32'h2);

    // R8: match on ch0 in the same cycle as a clear of bits 0 and 1.
    wr(3'd3, 32'd11);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h3;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    rd(3'd0, v); check("R8 set wins", v, 32'h1);
    check("R9 irq0", {28'h0, irq}, 32'h1);

    // R2 hold and R10 ignored counter writes.
    repeat (4) @(negedge clk);
    rd(3'd1, v); check("R2 hold", v, 32'd11);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R10 lo", v, 32'd11);
    rd(3'd2, v); check("R10 hi", v, 32'd0);

    // R3: upper status bits read zero even with all-ones write.
    wr(3'd0, 32'hFFFF_FFF0);
    rd(3'd0, v); check("R3 upper", v, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule